// File: doc/BRIEF.md
# Four-Bit Port Bank with Debug Takeover

This block manages four bidirectional pins. In normal operation each pin is a general-purpose I/O bit whose output level, drive enable and peripheral routing are set by software through a small write port. Each pin has an edge detector that records transitions in a per-bit flag, and a single interrupt request is raised when any enabled flag is set. The pads themselves are modelled as separate input, output and output-enable vectors, so the analog pad cell sits outside this block.

A dedicated test-mode input switches the bank between two named states. In state ST_PORT the port registers drive the pads. In state ST_JTAG the four pads carry the signals of an external debug test access port, and the port registers stop driving them. Transition T_ENTER (ST_PORT to ST_JTAG) is taken on a clock edge where the test-mode input is high. Transition T_LEAVE (ST_JTAG to ST_PORT) is taken on a clock edge where it is low. Pin 3 is the only pin the debug logic may drive, and it does so to return serial data.

Top module: `pinbank_top`

## Requirements
- R1: After reset every pad output enable is 0, every flag is 0, the interrupt request is 0, and all four debug outputs are 0.
- R2: In ST_PORT with function select 0 for a bit, that bit's pad output equals its output register and its pad enable equals its direction register.
- R3: In ST_PORT with function select 1 for a bit, the pad output takes that bit's peripheral signal instead: bit 0 takes the sub-main clock, and bits 1, 2 and 3 take timer outputs 0, 1 and 2. The pad enable still comes from the direction register.
- R4: `port_in_o` equals the pad input level two clock edges earlier, whatever the state or the function select.
- R5: Edge select 0 makes a rising pad edge set the flag, and edge select 1 makes a falling edge set it. The flag becomes visible on the third clock edge after the pad changes.
- R6: Writing the edge-select register never sets a flag by itself, even while the pad is held high.
- R7: A flag write loads the written value, so 0 clears and 1 sets. When a detected edge occurs in the same cycle as a clear, the flag ends up set.
- R8: `irq_o` is 1 exactly when some bit has both its flag and its interrupt enable set.
- R9: One edge after the test-mode input is sampled high, the bank is in ST_JTAG. Pads 0 to 2 are undriven, pad 3 drives `jtag_tdo_i` with enable `jtag_tdo_en_i`, and the debug outputs carry the raw pad inputs: TCK from pad 0, TMS from pad 1, TCLK from pad 2 and TDI from pad 3. One edge after the input is sampled low, port control drives the pads again.
- R10: Register select codes are: 0 output, 1 direction, 2 function select, 3 interrupt enable, 4 edge select, 5 flag. Writes to codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 1 | Requests debug takeover of the pads |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 4 | Register write data, one bit per pin |
| pad_in_i | input | 4 | Level seen at each pad |
| pad_out_o | output | 4 | Level driven onto each pad |
| pad_oe_o | output | 4 | Drive enable of each pad |
| smclk_i | input | 1 | Sub-main clock, peripheral signal for bit 0 |
| timer_out_i | input | 3 | Timer outputs 0 to 2, peripheral signals for bits 1 to 3 |
| jtag_tdo_i | input | 1 | Serial data from the test access port |
| jtag_tdo_en_i | input | 1 | Test access port drives pad 3 |
| jtag_tck_o | output | 1 | Test clock taken from pad 0 |
| jtag_tms_o | output | 1 | Mode select taken from pad 1 |
| jtag_tclk_o | output | 1 | Data-in or test clock taken from pad 2 |
| jtag_tdi_o | output | 1 | Serial data in taken from pad 3 |
| port_in_o | output | 4 | Synchronized input register |
| irq_flag_o | output | 4 | Interrupt flag register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A mode register stuck in the wrong state shows within one edge as pad enables that ignore the direction register, or as debug outputs that stay 0 while pads toggle. A synchronizer or edge-memory fault moves the flag out of its third-edge slot, or sets a flag on an edge-select write, and that shows on `irq_flag_o` the cycle it happens. A lost set-over-clear priority shows as a zero flag right after the colliding write.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Register select codes used on the write port
    typedef enum logic [2:0] {
        SEL_OUT  = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_FSEL = 3'd2,
        SEL_IE   = 3'd3,
        SEL_IES  = 3'd4,
        SEL_IFG  = 3'd5
    } reg_sel_e;

    // Ownership of the pads
    typedef enum logic {
        ST_PORT = 1'b0,
        ST_JTAG = 1'b1
    } bank_state_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    // Previous synchronized sample, used only for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[LAST];
    end

    assign level_o = stage_q[LAST];
    assign rise_o  = stage_q[LAST] & ~prev_q;
    assign fall_o  = ~stage_q[LAST] & prev_q;

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [2:0]   sel_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] fsel_q,
    output logic [W-1:0] ie_q,
    output logic [W-1:0] ifg_q
);
    logic [W-1:0] ies_q;
    logic [W-1:0] edge_hit;
    logic [W-1:0] ifg_base;

    // Edge select 0 picks rising, 1 picks falling
    assign edge_hit = (rise_i & ~ies_q) | (fall_i & ies_q);
    assign ifg_base = (we_i && sel_i == SEL_IFG) ? wdata_i : ifg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            fsel_q <= '0;
            ie_q   <= '0;
            ies_q  <= '0;
        end else if (we_i) begin
            unique case (sel_i)
                SEL_OUT:  out_q  <= wdata_i;
                SEL_DIR:  dir_q  <= wdata_i;
                SEL_FSEL: fsel_q <= wdata_i;
                SEL_IE:   ie_q   <= wdata_i;
                SEL_IES:  ies_q  <= wdata_i;
                default:  ;
            endcase
        end
    end

    // A set from a detected edge overrides a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ifg_q <= '0;
        else        ifg_q <= ifg_base | edge_hit;
    end

endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux #(
    parameter int W = 4
) (
    input  logic         in_jtag_i,
    input  logic [W-1:0] out_q_i,
    input  logic [W-1:0] dir_q_i,
    input  logic [W-1:0] fsel_q_i,
    input  logic [W-1:0] periph_i,
    input  logic         tdo_i,
    input  logic         tdo_en_i,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o
);
    localparam int TDO_BIT = W - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic port_lvl;
        assign port_lvl = fsel_q_i[b] ? periph_i[b] : out_q_i[b];

        if (b == TDO_BIT) begin : g_tdo
            assign pad_out_o[b] = in_jtag_i ? tdo_i    : port_lvl;
            assign pad_oe_o[b]  = in_jtag_i ? tdo_en_i : dir_q_i[b];
        end else begin : g_in
            assign pad_out_o[b] = in_jtag_i ? 1'b0 : port_lvl;
            assign pad_oe_o[b]  = in_jtag_i ? 1'b0 : dir_q_i[b];
        end
    end

endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       test_mode_i,
    input  logic       reg_we_i,
    input  logic [2:0] reg_sel_i,
    input  logic [3:0] reg_wdata_i,
    input  logic [3:0] pad_in_i,
    output logic [3:0] pad_out_o,
    output logic [3:0] pad_oe_o,
    input  logic       smclk_i,
    input  logic [2:0] timer_out_i,
    input  logic       jtag_tdo_i,
    input  logic       jtag_tdo_en_i,
    output logic       jtag_tck_o,
    output logic       jtag_tms_o,
    output logic       jtag_tclk_o,
    output logic       jtag_tdi_o,
    output logic [3:0] port_in_o,
    output logic [3:0] irq_flag_o,
    output logic       irq_o
);
    localparam int NB = 4;

    bank_state_e  state_q, state_d;
    logic         in_jtag;
    logic [NB-1:0] rise, fall;
    logic [NB-1:0] out_q, dir_q, fsel_q, ie_q, ifg_q;
    logic [NB-1:0] periph;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PORT;
        else        state_q <= state_d;
    end

    // Next state: T_ENTER and T_LEAVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PORT: if (test_mode_i)  state_d = ST_JTAG;
            ST_JTAG: if (!test_mode_i) state_d = ST_PORT;
        endcase
    end

    // State outputs
    always_comb begin
        in_jtag     = 1'b0;
        jtag_tck_o  = 1'b0;
        jtag_tms_o  = 1'b0;
        jtag_tclk_o = 1'b0;
        jtag_tdi_o  = 1'b0;
        unique case (state_q)
            ST_PORT: ;
            ST_JTAG: begin
                in_jtag     = 1'b1;
                jtag_tck_o  = pad_in_i[0];
                jtag_tms_o  = pad_in_i[1];
                jtag_tclk_o = pad_in_i[2];
                jtag_tdi_o  = pad_in_i[3];
            end
        endcase
    end

    assign periph = {timer_out_i, smclk_i};

    pinbank_sync #(.W(NB), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (pad_in_i),
        .level_o (port_in_o),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    pinbank_regs #(.W(NB)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .rise_i  (rise),
        .fall_i  (fall),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .fsel_q  (fsel_q),
        .ie_q    (ie_q),
        .ifg_q   (ifg_q)
    );

    pinbank_padmux #(.W(NB)) u_mux (
        .in_jtag_i (in_jtag),
        .out_q_i   (out_q),
        .dir_q_i   (dir_q),
        .fsel_q_i  (fsel_q),
        .periph_i  (periph),
        .tdo_i     (jtag_tdo_i),
        .tdo_en_i  (jtag_tdo_en_i),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o)
    );

    assign irq_flag_o = ifg_q;
    assign irq_o      = |(ifg_q & ie_q);

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_jtag,
    input logic       reg_we_i,
    input logic [2:0] reg_sel_i,
    input logic [3:0] pad_in_i,
    input logic [3:0] pad_oe_o,
    input logic [3:0] dir_q,
    input logic [3:0] port_in_o,
    input logic [3:0] irq_flag_o,
    input logic       irq_o,
    input logic       jtag_tck_o,
    input logic       jtag_tdi_o
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R9: debug state leaves pads 0..2 undriven
    a_r9_jtag_pads_released: assert property (@(posedge clk) disable iff (!rst_n)
        in_jtag |-> (pad_oe_o[2:0] == 3'b000));

    // R9: debug outputs follow the raw pads
    a_r9_jtag_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_jtag |-> (jtag_tck_o == pad_in_i[0] && jtag_tdi_o == pad_in_i[3]));

    // R2: port state drives enables from the direction register
    a_r2_port_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_jtag |-> (pad_oe_o == dir_q));

    // R4: input register is the pad two edges back
    a_r4_input_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (port_in_o == $past(pad_in_i, 2)));

    // R7: without a flag write no flag bit drops
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_sel_i == SEL_IFG) |=>
            ((irq_flag_o & $past(irq_flag_o)) == $past(irq_flag_o)));

    // R8: request needs a flag
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_flag_o != 4'b0000));

endmodule

bind pinbank_top pinbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_jtag    (in_jtag),
    .reg_we_i   (reg_we_i),
    .reg_sel_i  (reg_sel_i),
    .pad_in_i   (pad_in_i),
    .pad_oe_o   (pad_oe_o),
    .dir_q      (dir_q),
    .port_in_o  (port_in_o),
    .irq_flag_o (irq_flag_o),
    .irq_o      (irq_o),
    .jtag_tck_o (jtag_tck_o),
    .jtag_tdi_o (jtag_tdi_o)
);

// File: tb/tb_pinbank_top.sv
`timescale 1ns/1ps
module tb_pinbank_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_mode_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [2:0] reg_sel_i = '0;
    logic [3:0] reg_wdata_i = '0;
    logic [3:0] pad_in_i = '0;
    logic [3:0] pad_out_o, pad_oe_o;
    logic       smclk_i = 1'b0;
    logic [2:0] timer_out_i = '0;
    logic       jtag_tdo_i = 1'b0;
    logic       jtag_tdo_en_i = 1'b0;
    logic       jtag_tck_o, jtag_tms_o, jtag_tclk_o, jtag_tdi_o;
    logic [3:0] port_in_o, irq_flag_o;
    logic       irq_o;

    always #2.5 clk = ~clk;

    pinbank_top dut (.*);

    typedef enum int {F_OE, F_OUT, F_IN, F_FLAG, F_IRQ, F_JTAG} field_e;
    typedef struct {
        field_e     fld;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t queue_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    function automatic logic [3:0] observe(field_e f);
        case (f)
            F_OE:   return pad_oe_o;
            F_OUT:  return pad_out_o;
            F_IN:   return port_in_o;
            F_FLAG: return irq_flag_o;
            F_IRQ:  return {3'b000, irq_o};
            default: return {jtag_tdi_o, jtag_tclk_o, jtag_tms_o, jtag_tck_o};
        endcase
    endfunction

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (queue_q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it = queue_q.pop_front();
            act = observe(it.fld);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s field=%s actual=%b expected=%b",
                         it.req, it.fld.name(), act, it.exp);
            end
        end
    end

    task automatic expect_val(field_e f, logic [3:0] v, string req);
        item_t it;
        it.fld = f; it.exp = v; it.req = req;
        queue_q.push_back(it);
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] sel, logic [3:0] data);
        reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
        tick(1);
        reg_we_i = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_val(F_OE, 4'b0000, "R1");
        expect_val(F_FLAG, 4'b0000, "R1");
        expect_val(F_IRQ, 4'b0000, "R1");
        expect_val(F_JTAG, 4'b0000, "R1");
        tick(1);

        // R2 plain GPIO
        wr(3'd0, 4'b1010);
        wr(3'd1, 4'b0110);
        expect_val(F_OUT, 4'b1010, "R2");
        expect_val(F_OE, 4'b0110, "R2");
        tick(1);

        // R10 unused codes change nothing
        wr(3'd6, 4'b1111);
        wr(3'd7, 4'b1111);
        expect_val(F_OUT, 4'b1010, "R10");
        expect_val(F_OE, 4'b0110, "R10");
        expect_val(F_FLAG, 4'b0000, "R10");
        expect_val(F_IRQ, 4'b0000, "R10");
        tick(1);

        // R3 peripheral routing: periph vector = {timer2,timer1,timer0,smclk} = 0101
        smclk_i = 1'b1; timer_out_i = 3'b010;
        wr(3'd2, 4'b0011);
        expect_val(F_OUT, 4'b1001, "R3");
        expect_val(F_OE, 4'b0110, "R3");
        tick(1);
        wr(3'd2, 4'b1111);
        expect_val(F_OUT, 4'b0101, "R3");
        tick(1);

        // R4 and R5 rising edges on bits 0 and 2
        pad_in_i = 4'b0101;
        tick(1);
        expect_val(F_IN, 4'b0000, "R4");
        tick(1);
        expect_val(F_IN, 4'b0101, "R4");
        expect_val(F_FLAG, 4'b0000, "R5");
        tick(1);
        expect_val(F_FLAG, 4'b0101, "R5");
        expect_val(F_IRQ, 4'b0000, "R8");
        tick(1);
        // R8 enable one flagged bit
        wr(3'd3, 4'b0100);
        expect_val(F_IRQ, 4'b0001, "R8");
        tick(1);
        // R7 clear by writing 0
        wr(3'd5, 4'b0000);
        expect_val(F_FLAG, 4'b0000, "R7");
        expect_val(F_IRQ, 4'b0000, "R7");
        tick(1);

        // R5 falling edge on bit 0 only (bit 2 still rising-sensitive)
        wr(3'd4, 4'b0001);
        pad_in_i = 4'b0000;
        tick(3);
        expect_val(F_FLAG, 4'b0001, "R5");
        tick(1);
        wr(3'd5, 4'b0000);

        // R6 edge-select writes do not set flags
        wr(3'd4, 4'b1111);
        wr(3'd4, 4'b0000);
        tick(3);
        expect_val(F_FLAG, 4'b0000, "R6");
        tick(1);
        pad_in_i = 4'b1000;
        tick(3);
        expect_val(F_FLAG, 4'b1000, "R5");
        tick(1);
        wr(3'd5, 4'b0000);
        wr(3'd4, 4'b1111);
        tick(3);
        expect_val(F_FLAG, 4'b0000, "R6");
        tick(1);

        // R7 write 1 sets, then edge wins over a same-cycle clear
        wr(3'd5, 4'b0010);
        expect_val(F_FLAG, 4'b0010, "R7");
        pad_in_i = 4'b0000;
        tick(2);
        wr(3'd5, 4'b0000);
        expect_val(F_FLAG, 4'b1000, "R7");
        tick(1);
        wr(3'd5, 4'b0000);
        expect_val(F_FLAG, 4'b0000, "R7");
        tick(1);

        // R9 takeover
        test_mode_i = 1'b1; jtag_tdo_i = 1'b1; jtag_tdo_en_i = 1'b1;
        pad_in_i = 4'b0110;
        tick(1);
        expect_val(F_OE, 4'b1000, "R9");
        expect_val(F_OUT, 4'b1000, "R9");
        expect_val(F_JTAG, 4'b0110, "R9");
        tick(1);
        expect_val(F_IN, 4'b0110, "R4");
        jtag_tdo_en_i = 1'b0;
        tick(1);
        expect_val(F_OE, 4'b0000, "R9");
        test_mode_i = 1'b0;
        tick(1);
        expect_val(F_OE, 4'b0110, "R9");
        expect_val(F_OUT, 4'b0101, "R9");
        expect_val(F_JTAG, 4'b0000, "R9");
        tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule